// File: doc/BRIEF.md
# Register Status Scoreboard

This block keeps three one-bit status flags for each of 512 physical registers shared by four execution clusters. The flags are *valid* (the register's content may be read), *in-flight* (an instruction writing the register has entered the select stage and has not yet issued) and *remote-wanted* (another cluster will need the register's value forwarded). A register number is 9 bits wide. Its top two bits name the owning cluster (00, 01, 10, 11), and the low seven bits pick one of the 128 registers inside that cluster.

Four event sources update the flags. The first select cycle reports the destination of a newly read instruction. The issue cycle reports an instruction that was sent, along with its destination, two sources and the busy state of the target resource. Writeback reports a destination whose result is complete. Up to four forwarding-complete strobes per cycle report registers whose forwarding has finished. Every update takes effect at the next clock edge. When two events hit the same flag of the same register in one cycle, a fixed priority decides the result. Three combinational lookup ports (two source, one destination) return all three flags of the addressed registers as they are currently stored.

Top module: `reg_status_sb`

## Requirements
- R1: After reset, every register's valid flag reads 1, and its in-flight and remote-wanted flags read 0.
- R2: A first-select-cycle event (`sel_vld`) clears the valid flag and sets the in-flight flag of `sel_dst` from the next clock edge.
- R3: A writeback event (`wb_vld`) sets the valid flag of `wb_dst` from the next clock edge.
- R4: If the select event and the writeback event name the same register in one cycle, the valid flag ends at 0. If they name different registers, both updates apply.
- R5: An issue event (`iss_vld`) clears the in-flight flag of `iss_dst` only when `iss_busy` is 0. With `iss_busy` at 1, the flag keeps its value.
- R6: If a select event sets the in-flight flag of the same register that an issue event clears in the same cycle, the flag ends at 1.
- R7: An issue event sets the remote-wanted flag of source 1 when `iss_use[0]` is 1, and of source 2 when `iss_use[1]` is 1. In each case the source's bits [8:7] must also differ from those of `iss_dst`. A source in the destination's cluster, or one whose use bit is 0, is left unchanged.
- R8: Forwarding-complete strobe k (`fwd_done[k]`, index in `fwd_idx[9k+8:9k]`) clears the remote-wanted flag of its register. All four strobes may act in the same cycle.
- R9: If an issue event sets a remote-wanted flag and a forwarding strobe clears it in the same cycle, the flag ends at 1.
- R10: The lookup outputs show the stored flags of the addressed registers without delay. They do not reflect updates that are still pending for the coming clock edge.
- R11: Registers that no event addresses keep all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_vld | input | 1 | First-select-cycle event strobe |
| sel_dst | input | 9 | Destination register of the selected instruction |
| iss_vld | input | 1 | Issue event strobe (instruction sent) |
| iss_busy | input | 1 | Target cluster resource busy |
| iss_dst | input | 9 | Destination register of the issued instruction |
| iss_src1 | input | 9 | Source 1 register of the issued instruction |
| iss_src2 | input | 9 | Source 2 register of the issued instruction |
| iss_use | input | 2 | Bit 0: source 1 present; bit 1: source 2 present |
| wb_vld | input | 1 | Writeback completion strobe |
| wb_dst | input | 9 | Register whose result completed |
| fwd_done | input | 4 | Forwarding-complete strobes, one per port |
| fwd_idx | input | 36 | Packed register numbers, port k in bits [9k+8:9k] |
| lk_src1 | input | 9 | Lookup index, source 1 |
| lk_src2 | input | 9 | Lookup index, source 2 |
| lk_dst | input | 9 | Lookup index, destination |
| src1_valid | output | 1 | Valid flag at `lk_src1` |
| src1_infl | output | 1 | In-flight flag at `lk_src1` |
| src1_want | output | 1 | Remote-wanted flag at `lk_src1` |
| src2_valid | output | 1 | Valid flag at `lk_src2` |
| src2_infl | output | 1 | In-flight flag at `lk_src2` |
| src2_want | output | 1 | Remote-wanted flag at `lk_src2` |
| dst_valid | output | 1 | Valid flag at `lk_dst` |
| dst_infl | output | 1 | In-flight flag at `lk_dst` |
| dst_want | output | 1 | Remote-wanted flag at `lk_dst` |

## Verification
The assertions assume that every strobe and index is a known value from the first clock edge on. Each flag-change property excludes the one competing event that could override it. For example, the writeback check ignores a cycle in which the select event names the same register, and the forwarding check ignores cycles that carry an issue event. The bench therefore holds all strobes low through reset and drives inputs only just after a rising edge. Conflicts are created on purpose and only in the tests that target the priority rules, so the remaining tests see one event per flag and register.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int CLUSTER_W = 2;
    localparam int LOCAL_W   = 7;
    localparam int IDX_W     = CLUSTER_W + LOCAL_W;
    localparam int NUM_REGS  = 1 << IDX_W;
    localparam int NUM_FWD   = 4;

    typedef logic [IDX_W-1:0] reg_idx_t;

    function automatic logic [CLUSTER_W-1:0] cluster_of(input reg_idx_t idx);
        return idx[IDX_W-1 -: CLUSTER_W];
    endfunction
endpackage

// File: rtl/sb_onehot.sv
module sb_onehot #(
    parameter  int IDX_W = 9,
    localparam int N     = 1 << IDX_W
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     vec
);
    always_comb begin
        vec = '0;
        if (en) begin
            vec[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/sb_flag_bank.sv
module sb_flag_bank #(
    parameter int N        = 512,
    parameter bit RST_VAL  = 1'b0,
    parameter bit SET_WINS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    logic [N-1:0] nxt;

    generate
        if (SET_WINS) begin : g_set_wins
            assign nxt = (flags & ~clr_vec) | set_vec;
        end else begin : g_clr_wins
            assign nxt = (flags | set_vec) & ~clr_vec;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= {N{RST_VAL}};
        end else begin
            flags <= nxt;
        end
    end
endmodule

// File: rtl/sb_read.sv
module sb_read #(
    parameter  int IDX_W = 9,
    localparam int N     = 1 << IDX_W
) (
    input  logic [N-1:0]     rdy,
    input  logic [N-1:0]     infl,
    input  logic [N-1:0]     want,
    input  logic [IDX_W-1:0] idx,
    output logic             o_valid,
    output logic             o_infl,
    output logic             o_want
);
    always_comb begin
        o_valid = rdy[idx];
        o_infl  = infl[idx];
        o_want  = want[idx];
    end
endmodule

// File: rtl/reg_status_sb.sv
module reg_status_sb
    import sb_pkg::*;
#(
    parameter  int NFWD = sb_pkg::NUM_FWD,
    localparam int IW   = sb_pkg::IDX_W,
    localparam int NR   = sb_pkg::NUM_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_vld,
    input  logic [IW-1:0]    sel_dst,
    input  logic             iss_vld,
    input  logic             iss_busy,
    input  logic [IW-1:0]    iss_dst,
    input  logic [IW-1:0]    iss_src1,
    input  logic [IW-1:0]    iss_src2,
    input  logic [1:0]       iss_use,
    input  logic             wb_vld,
    input  logic [IW-1:0]    wb_dst,
    input  logic [NFWD-1:0]  fwd_done,
    input  logic [NFWD*IW-1:0] fwd_idx,
    input  logic [IW-1:0]    lk_src1,
    input  logic [IW-1:0]    lk_src2,
    input  logic [IW-1:0]    lk_dst,
    output logic             src1_valid,
    output logic             src1_infl,
    output logic             src1_want,
    output logic             src2_valid,
    output logic             src2_infl,
    output logic             src2_want,
    output logic             dst_valid,
    output logic             dst_infl,
    output logic             dst_want
);
    logic [NR-1:0] ready_q, sched_q, pend_q;
    logic [NR-1:0] sel_vec, wb_vec, iss_clr_vec, s1_vec, s2_vec;
    logic [NR-1:0] fwd_any;
    logic [NFWD-1:0][NR-1:0] fwd_vec;
    logic s1_en, s2_en, iss_clr_en;

    // Cross-cluster source detection and not-busy issue qualification
    assign s1_en      = iss_vld && iss_use[0] && (cluster_of(iss_src1) != cluster_of(iss_dst));
    assign s2_en      = iss_vld && iss_use[1] && (cluster_of(iss_src2) != cluster_of(iss_dst));
    assign iss_clr_en = iss_vld && !iss_busy;

    sb_onehot #(.IDX_W(IW)) u_dec_sel (.en(sel_vld),    .idx(sel_dst),  .vec(sel_vec));
    sb_onehot #(.IDX_W(IW)) u_dec_wb  (.en(wb_vld),     .idx(wb_dst),   .vec(wb_vec));
    sb_onehot #(.IDX_W(IW)) u_dec_iss (.en(iss_clr_en), .idx(iss_dst),  .vec(iss_clr_vec));
    sb_onehot #(.IDX_W(IW)) u_dec_s1  (.en(s1_en),      .idx(iss_src1), .vec(s1_vec));
    sb_onehot #(.IDX_W(IW)) u_dec_s2  (.en(s2_en),      .idx(iss_src2), .vec(s2_vec));

    generate
        for (genvar f = 0; f < NFWD; f++) begin : g_fwd
            sb_onehot #(.IDX_W(IW)) u_dec_fwd (
                .en  (fwd_done[f]),
                .idx (fwd_idx[f*IW +: IW]),
                .vec (fwd_vec[f])
            );
        end
    endgenerate

    always_comb begin
        fwd_any = '0;
        for (int f = 0; f < NFWD; f++) begin
            fwd_any = fwd_any | fwd_vec[f];
        end
    end

    // Valid: select-cycle clear beats writeback set on the same register
    sb_flag_bank #(.N(NR), .RST_VAL(1'b1), .SET_WINS(1'b0)) u_ready (
        .clk(clk), .rst_n(rst_n), .set_vec(wb_vec), .clr_vec(sel_vec), .flags(ready_q));

    // In-flight: newer select-cycle set beats issue clear
    sb_flag_bank #(.N(NR), .RST_VAL(1'b0), .SET_WINS(1'b1)) u_sched (
        .clk(clk), .rst_n(rst_n), .set_vec(sel_vec), .clr_vec(iss_clr_vec), .flags(sched_q));

    // Remote-wanted: issue set beats forwarding-complete clear
    sb_flag_bank #(.N(NR), .RST_VAL(1'b0), .SET_WINS(1'b1)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(s1_vec | s2_vec), .clr_vec(fwd_any), .flags(pend_q));

    sb_read #(.IDX_W(IW)) u_rd_s1 (.rdy(ready_q), .infl(sched_q), .want(pend_q), .idx(lk_src1),
        .o_valid(src1_valid), .o_infl(src1_infl), .o_want(src1_want));
    sb_read #(.IDX_W(IW)) u_rd_s2 (.rdy(ready_q), .infl(sched_q), .want(pend_q), .idx(lk_src2),
        .o_valid(src2_valid), .o_infl(src2_infl), .o_want(src2_want));
    sb_read #(.IDX_W(IW)) u_rd_d  (.rdy(ready_q), .infl(sched_q), .want(pend_q), .idx(lk_dst),
        .o_valid(dst_valid), .o_infl(dst_infl), .o_want(dst_want));
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int IW   = 9,
    parameter int NFWD = 4,
    localparam int NR  = 1 << IW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_vld,
    input logic [IW-1:0]     sel_dst,
    input logic              iss_vld,
    input logic              iss_busy,
    input logic [IW-1:0]     iss_dst,
    input logic [IW-1:0]     iss_src1,
    input logic [IW-1:0]     iss_src2,
    input logic [1:0]        iss_use,
    input logic              wb_vld,
    input logic [IW-1:0]     wb_dst,
    input logic [NFWD-1:0]   fwd_done,
    input logic [NFWD*IW-1:0] fwd_idx,
    input logic [NR-1:0]     rdy_vec,
    input logic [NR-1:0]     sch_vec,
    input logic [NR-1:0]     pnd_vec
);
    // R2 R4
    sel_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |=> !rdy_vec[$past(sel_dst)]);

    // R2 R6
    sel_sets_infl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |=> sch_vec[$past(sel_dst)]);

    // R3
    wb_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && !(sel_vld && sel_dst == wb_dst)) |=> rdy_vec[$past(wb_dst)]);

    // R5
    iss_clears_infl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_busy && !(sel_vld && sel_dst == iss_dst)) |=> !sch_vec[$past(iss_dst)]);

    // R5
    busy_keeps_infl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_busy && !sel_vld) |=> (sch_vec[$past(iss_dst)] == $past(sch_vec[iss_dst])));

    // R7 R9
    src1_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_use[0] && iss_src1[IW-1 -: 2] != iss_dst[IW-1 -: 2]) |=> pnd_vec[$past(iss_src1)]);

    // R7 R9
    src2_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_use[1] && iss_src2[IW-1 -: 2] != iss_dst[IW-1 -: 2]) |=> pnd_vec[$past(iss_src2)]);

    generate
        for (genvar f = 0; f < NFWD; f++) begin : g_fchk
            // R8
            fwd_clears_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fwd_done[f] && !iss_vld) |=> !pnd_vec[$past(fwd_idx[f*IW +: IW])]);
        end
    endgenerate
endmodule

bind reg_status_sb sb_checker #(.IW(IW), .NFWD(NFWD)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_dst(sel_dst),
    .iss_vld(iss_vld), .iss_busy(iss_busy), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_use(iss_use),
    .wb_vld(wb_vld), .wb_dst(wb_dst), .fwd_done(fwd_done), .fwd_idx(fwd_idx),
    .rdy_vec(ready_q), .sch_vec(sched_q), .pnd_vec(pend_q));

// File: tb/sim_reg_status_sb.sv
`timescale 1ns/1ps
module sim_reg_status_sb;
    logic clk = 0, rst_n = 0;
    logic sel_vld = 0, iss_vld = 0, iss_busy = 0, wb_vld = 0;
    logic [8:0] sel_dst = 0, iss_dst = 0, iss_src1 = 0, iss_src2 = 0, wb_dst = 0;
    logic [1:0] iss_use = 0;
    logic [3:0] fwd_done = 0;
    logic [35:0] fwd_idx = 0;
    logic [8:0] lk_src1 = 0, lk_src2 = 0, lk_dst = 0;
    logic src1_valid, src1_infl, src1_want, src2_valid, src2_infl, src2_want;
    logic dst_valid, dst_infl, dst_want;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    reg_status_sb u0 (.*);

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        sel_vld = 0; iss_vld = 0; iss_busy = 0; wb_vld = 0; fwd_done = 0; iss_use = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    task automatic look(input logic [8:0] idx, input string req, input logic v, input logic i, input logic w);
        lk_dst = idx; #1;
        chk(req, $sformatf("valid[%0d]", idx), dst_valid, v);
        chk(req, $sformatf("infl[%0d]", idx),  dst_infl, i);
        chk(req, $sformatf("want[%0d]", idx),  dst_want, w);
    endtask

    task automatic t_reset();
        look(9'd0, "R1", 1, 0, 0);
        look(9'd127, "R1", 1, 0, 0);
        look(9'd300, "R1", 1, 0, 0);
        look(9'd511, "R1", 1, 0, 0);
    endtask

    task automatic t_select();
        sel_vld = 1; sel_dst = 9'd130;
        look(9'd130, "R10", 1, 0, 0);   // pending update not yet visible
        tick();
        look(9'd130, "R2", 0, 1, 0);
        look(9'd131, "R11", 1, 0, 0);
    endtask

    task automatic t_writeback();
        wb_vld = 1; wb_dst = 9'd130;
        tick();
        look(9'd130, "R3", 1, 1, 0);
    endtask

    task automatic t_valid_conflict();
        sel_vld = 1; sel_dst = 9'd200; wb_vld = 1; wb_dst = 9'd200;
        tick();
        look(9'd200, "R4", 0, 1, 0);
        sel_vld = 1; sel_dst = 9'd10; wb_vld = 1; wb_dst = 9'd200;
        tick();
        look(9'd200, "R4", 1, 1, 0);
        look(9'd10, "R4", 0, 1, 0);
    endtask

    task automatic t_issue_busy();
        iss_vld = 1; iss_busy = 1; iss_dst = 9'd130; iss_src1 = 9'd131; iss_src2 = 9'd132;
        tick();
        look(9'd130, "R5", 1, 1, 0);
        iss_vld = 1; iss_busy = 0; iss_dst = 9'd130;
        tick();
        look(9'd130, "R5", 1, 0, 0);
    endtask

    task automatic t_infl_conflict();
        sel_vld = 1; sel_dst = 9'd40; iss_vld = 1; iss_busy = 0; iss_dst = 9'd40;
        tick();
        look(9'd40, "R6", 0, 1, 0);
    endtask

    task automatic t_want_set();
        iss_vld = 1; iss_busy = 1; iss_dst = 9'd5; iss_src1 = 9'd200; iss_src2 = 9'd20; iss_use = 2'b11;
        tick();
        lk_src1 = 9'd200; lk_src2 = 9'd20; #1;
        chk("R7", "src1 cross-cluster want", src1_want, 1);
        chk("R7", "src2 same-cluster want", src2_want, 0);
        chk("R10", "src1 lookup valid", src1_valid, 1);
        iss_vld = 1; iss_busy = 1; iss_dst = 9'd5; iss_src1 = 9'd300; iss_src2 = 9'd400; iss_use = 2'b10;
        tick();
        lk_src1 = 9'd300; lk_src2 = 9'd400; #1;
        chk("R7", "unused src1 want", src1_want, 0);
        chk("R7", "src2 cross-cluster want", src2_want, 1);
    endtask

    task automatic t_fwd_clear();
        fwd_done = 4'b1001; fwd_idx = '0;
        fwd_idx[8:0] = 9'd200; fwd_idx[35:27] = 9'd400;
        tick();
        look(9'd200, "R8", 1, 1, 0);
        look(9'd400, "R8", 1, 0, 0);
    endtask

    task automatic t_want_conflict();
        iss_vld = 1; iss_busy = 1; iss_dst = 9'd5; iss_src1 = 9'd450; iss_use = 2'b01;
        fwd_done = 4'b0010; fwd_idx = '0; fwd_idx[17:9] = 9'd450;
        tick();
        look(9'd450, "R9", 1, 0, 1);
        fwd_done = 4'b0100; fwd_idx = '0; fwd_idx[26:18] = 9'd450;
        tick();
        look(9'd450, "R8", 1, 0, 0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_select();
        t_writeback();
        t_valid_conflict();
        t_issue_busy();
        t_infl_conflict();
        t_want_set();
        t_fwd_clear();
        t_want_conflict();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule